// File: doc/BRIEF.md
# Unsigned Array Multiplier

This block multiplies two unsigned operands of N bits each and returns the full product of 2N bits. It is purely combinational: it holds no state, has no clock, and its output follows any change on its inputs once the gate delays settle. The default width is N = 5, which gives a 10-bit product. N must be at least 2.

The product is built from explicit gates, not from a behavioural multiply operator. The first stage is a matrix of N×N two-input AND gates. Row i of that matrix is operand A masked by bit i of operand B, and it is placed i bit positions to the left without padding. N-1 rippling adder tiers then accumulate these rows. Each tier uses a half adder in its lowest position and full adders above it, and both kinds of cell are made of XOR, AND and OR gates.

Each tier retires one product bit from the bottom of its sum and passes the rest of the sum, together with its carry out, up to the next tier. The last tier supplies the upper half of the product. Signed operands are not supported.

Top module: `umul_array`

## Requirements
- R1: For every pair of operand values, `product` equals the unsigned value of `op_a` times the unsigned value of `op_b`, zero-extended to 2N bits.
- R2: If either operand is zero, `product` is zero, whatever the other operand is.
- R3: If one operand is 1, `product` equals the other operand zero-extended to 2N bits, in either operand order.
- R4: With both operands at their maximum of 2^N-1 (31 at N=5), `product` is (2^N-1)^2 (961, hex 3C1). Bit 2N-1 of `product` is 1; it is driven by the carry out of the last tier.
- R5: Row i of the AND matrix equals `op_a` when bit i of `op_b` is 1, and zero otherwise. So when `op_b` has only bit i set, `product` equals `op_a` shifted left by i.
- R6: Bit 0 of `product` is the AND of bit 0 of `op_a` and bit 0 of `op_b`, with no adder on its path.
- R7: Each half-adder cell gives sum + 2·carry = a + b. Each full-adder cell gives sum + 2·carry = a + b + carry_in.
- R8: Each of the N-1 tiers outputs, as its sum together with its carry out, the (N+1)-bit total of its two N-bit inputs.
- R9: `product` settles from the operands alone, with no clock edge. A change of operands between clock edges is seen on `product` within the same clock phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned; bit i enables partial-product row i |
| product | output | 2N | Unsigned product of op_a and op_b |

## Verification
The hardest case to reach from the ports is a carry that ripples through a full tier into the carry out of the last tier, which is the product's top bit. It occurs only when both operands are dense with ones. Exhaustive sweeps of all 1024 operand pairs cover it, and the all-ones pair (31×31) targets it directly. Single-bit multipliers isolate each partial-product row, so a fault in one AND gate shows up as a shifted copy of `op_a` that is wrong.

// File: rtl/umul_pkg.sv
package umul_pkg;

  localparam int unsigned UMUL_DEF_W = 5;

  // number of rippling adder tiers needed to reduce w partial products
  function automatic int unsigned tier_count(input int unsigned w);
    return w - 1;
  endfunction

endpackage

// File: rtl/umul_half_add.sv
module umul_half_add (
  input  logic a,
  input  logic b,
  output logic s,
  output logic c
);

  xor g_sum (s, a, b);
  and g_car (c, a, b);

  always_comb begin
    if (!$isunknown({a, b, s, c}))
      assert_ha_sum_R7: assert ({c, s} == 2'(a) + 2'(b))
        else $error("half adder: a=%b b=%b gave c=%b s=%b", a, b, c, s);
  end

endmodule

// File: rtl/umul_full_add.sv
module umul_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);

  logic prop;
  logic gen;
  logic pass;

  xor g_prop (prop, a, b);
  xor g_sum  (s, prop, ci);
  and g_gen  (gen, a, b);
  and g_pass (pass, prop, ci);
  or  g_car  (co, gen, pass);

  always_comb begin
    if (!$isunknown({a, b, ci, s, co}))
      assert_fa_sum_R7: assert ({co, s} == 2'(a) + 2'(b) + 2'(ci))
        else $error("full adder: a=%b b=%b ci=%b gave co=%b s=%b", a, b, ci, co, s);
  end

endmodule

// File: rtl/umul_pp_matrix.sv
module umul_pp_matrix #(
  parameter int unsigned N = umul_pkg::UMUL_DEF_W
) (
  input  logic [N-1:0]        mcand,
  input  logic [N-1:0]        mplier,
  output logic [N-1:0][N-1:0] rows
);

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      and g_and (rows[i][j], mcand[j], mplier[i]);
    end

    always_comb begin
      if (!$isunknown({mcand, mplier[i], rows[i]}))
        assert_pp_row_R5: assert (rows[i] == (mplier[i] ? mcand : '0))
          else $error("pp row %0d = %b, multiplier bit %b", i, rows[i], mplier[i]);
    end
  end

endmodule

// File: rtl/umul_ripple_tier.sv
module umul_ripple_tier #(
  parameter int unsigned N = umul_pkg::UMUL_DEF_W
) (
  input  logic [N-1:0] acc_in,
  input  logic [N-1:0] row_in,
  output logic [N-1:0] sum,
  output logic         cout
);

  logic [N-1:0] carry;

  for (genvar j = 0; j < N; j++) begin : g_pos
    if (j == 0) begin : g_ha
      umul_half_add u_ha (
        .a (acc_in[j]),
        .b (row_in[j]),
        .s (sum[j]),
        .c (carry[j])
      );
    end else begin : g_fa
      umul_full_add u_fa (
        .a  (acc_in[j]),
        .b  (row_in[j]),
        .ci (carry[j-1]),
        .s  (sum[j]),
        .co (carry[j])
      );
    end
  end

  assign cout = carry[N-1];

  always_comb begin
    if (!$isunknown({acc_in, row_in, sum, cout}))
      assert_tier_total_R8: assert ({cout, sum} == (N+1)'(acc_in) + (N+1)'(row_in))
        else $error("tier: %0d + %0d gave %0d", acc_in, row_in, {cout, sum});
  end

endmodule

// File: rtl/umul_array.sv
module umul_array #(
  parameter int unsigned N = umul_pkg::UMUL_DEF_W
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] product
);

  localparam int unsigned TIERS = umul_pkg::tier_count(N);
  localparam int unsigned PW    = 2 * N;

  logic [N-1:0][N-1:0] pp;
  logic [N-1:0]        tier_acc [TIERS];
  logic [N-1:0]        tier_sum [TIERS];
  logic [TIERS-1:0]    tier_co;

  umul_pp_matrix #(.N(N)) u_matrix (
    .mcand  (op_a),
    .mplier (op_b),
    .rows   (pp)
  );

  for (genvar t = 0; t < TIERS; t++) begin : g_tier
    if (t == 0) begin : g_first
      // bit 0 of row 0 leaves directly as product bit 0
      assign tier_acc[t] = {1'b0, pp[0][N-1:1]};
    end else begin : g_next
      assign tier_acc[t] = {tier_co[t-1], tier_sum[t-1][N-1:1]};
    end

    umul_ripple_tier #(.N(N)) u_tier (
      .acc_in (tier_acc[t]),
      .row_in (pp[t+1]),
      .sum    (tier_sum[t]),
      .cout   (tier_co[t])
    );
  end

  always_comb begin
    product    = '0;
    product[0] = pp[0][0];
    for (int t = 0; t < TIERS; t++) product[t+1] = tier_sum[t][0];
    product[PW-1:N] = {tier_co[TIERS-1], tier_sum[TIERS-1][N-1:1]};
  end

  always_comb begin
    if (!$isunknown({op_a, op_b, product})) begin
      assert_product_R1: assert (product == PW'(op_a) * PW'(op_b))
        else $error("product %0d for %0d x %0d", product, op_a, op_b);
      assert_lsb_R6: assert (product[0] == (op_a[0] & op_b[0]))
        else $error("product bit 0 wrong");
    end
  end

endmodule

// File: tb/test_umul_array.sv
module test_umul_array;

  localparam int N  = 5;
  localparam int PW = 2 * N;
  localparam int MAXV = (1 << N) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]  opa = '0;
  logic [N-1:0]  opb = '0;
  logic [PW-1:0] prod;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  umul_array #(.N(N)) i_umul_array (
    .op_a    (opa),
    .op_b    (opb),
    .product (prod)
  );

  // a, b, expected product
  localparam logic [19:0] VECS [16] = '{
    {5'd0,  5'd0,  10'd0},
    {5'd31, 5'd0,  10'd0},
    {5'd0,  5'd31, 10'd0},
    {5'd1,  5'd17, 10'd17},
    {5'd23, 5'd1,  10'd23},
    {5'd31, 5'd31, 10'd961},
    {5'd16, 5'd16, 10'd256},
    {5'd2,  5'd3,  10'd6},
    {5'd10, 5'd21, 10'd210},
    {5'd31, 5'd1,  10'd31},
    {5'd7,  5'd9,  10'd63},
    {5'd19, 5'd27, 10'd513},
    {5'd30, 5'd30, 10'd900},
    {5'd8,  5'd4,  10'd32},
    {5'd5,  5'd25, 10'd125},
    {5'd31, 5'd16, 10'd496}
  };

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%0d b=%0d actual=%0d expected=%0d", tag, opa, opb, act, exp);
    end
  endtask

  // drive just after a rising edge, sample at the falling edge
  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b);
    @(posedge clk);
    opa = a;
    opb = b;
    @(negedge clk);
  endtask

  initial begin
    // idle state: both operands zero
    @(negedge clk);
    check("R2 idle zero", prod, '0);

    // vector table (R1 R2 R3 R4)
    for (int v = 0; v < 16; v++) begin
      apply(VECS[v][19:15], VECS[v][14:10]);
      check("R1 table", prod, VECS[v][9:0]);
    end

    // zero operand in either position
    for (int x = 0; x <= MAXV; x++) begin
      apply(N'(x), '0);
      check("R2 a*0", prod, '0);
      apply('0, N'(x));
      check("R2 0*b", prod, '0);
    end

    // identity operand in either position
    for (int x = 0; x <= MAXV; x++) begin
      apply(N'(1), N'(x));
      check("R3 1*b", prod, PW'(x));
      apply(N'(x), N'(1));
      check("R3 a*1", prod, PW'(x));
    end

    // all-ones operands: 961, top bit from final carry
    apply(N'(MAXV), N'(MAXV));
    check("R4 max*max", prod, 10'h3C1);
    check("R4 msb", PW'(prod[PW-1]), PW'(1));

    // single-bit multipliers isolate one partial-product row
    for (int i = 0; i < N; i++) begin
      apply(N'(21), N'(1 << i));
      check("R5 row 21", prod, PW'(21 << i));
      apply(N'(MAXV), N'(1 << i));
      check("R5 row max", prod, PW'(MAXV << i));
    end

    // bit 0 is the AND of the operand low bits
    for (int k = 0; k < 4; k++) begin
      apply(N'(6 | (k & 1)), N'(10 | (k >> 1)));
      check("R6 lsb", PW'(prod[0]), PW'((k & 1) & (k >> 1)));
    end

    // operand change between clock edges, no edge in between
    @(posedge clk);
    #1;
    opa = N'(13);
    opb = N'(11);
    #1;
    check("R9 no clock 13*11", prod, PW'(143));
    opb = N'(29);
    #1;
    check("R9 no clock 13*29", prod, PW'(377));

    // exhaustive sweep exercising every cell (R1 R7 R8)
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        apply(N'(a), N'(b));
        check("R1 R7 R8 exhaustive", prod, PW'(a * b));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule